// File: doc/BRIEF.md
# Received Packet Filter and Payload Loader

This block sits behind a bit-to-byte deserializer in a sub-GHz receiver. After the sync word has been found, the upstream logic pulses `frame_start` and then hands over one byte at a time with `byte_vld`. The block removes the optional payload whitening and works out how long the payload is. It can do this from a fixed configured length, or from a length byte at the head of the payload, which it checks against a limit.

Packets are dropped when the length byte is over the limit or when the address byte fails a four-way node-address filter. The block recomputes a 16-bit CRC over the payload and compares it with the two CRC bytes that follow. Accepted payload bytes are stored in plain form in a 64-entry receive FIFO. A dropped packet leaves the FIFO exactly as it found it.

At the end of a packet the block pulses `payload_ready` and updates `crc_ok`. A failed CRC can optionally flush the FIFO. The host drains the FIFO through a first-word-fall-through pop port between packets.

Top module: `pkt_rx_filter`

## Requirements
- R1: In fixed-length mode (`cfg_var_len`=0), exactly `cfg_max_len` bytes after `frame_start` form the payload, and each of them is written to the FIFO in arrival order.
- R2: In variable-length mode, the first byte after `frame_start` is a length L that counts the payload bytes after it. The length byte itself stays in the FIFO, followed by the L bytes, so the FIFO gains L+1 entries.
- R3: In variable-length mode, a length byte greater than `cfg_max_len` drops the packet. The FIFO level does not change, no `payload_ready` pulse is produced, and `crc_ok` keeps its value. A length equal to the limit is accepted.
- R4: The address byte is the first payload byte after the length byte, or the very first payload byte in fixed mode. `cfg_addr_mode` selects the filter: 00 accepts any address; 01 accepts only `cfg_node_addr`; 10 also accepts 0x00; 11 also accepts 0x00 and 0xFF. A variable-length packet with L=0 carries no address byte and is accepted.
- R5: A packet whose address is rejected is dropped. The FIFO returns to the level it had before the packet (the length byte already written is withdrawn), and no `payload_ready` pulse occurs.
- R6: With `cfg_white_en`=1, each payload byte and each CRC byte has been XORed with a PN9 mask, and the block removes that mask. The mask comes from a 9-bit register s, seeded to 0x1FF at `frame_start`. Each byte's mask is s[7:0]. Between bytes the register steps 8 times, each step computing fb=s[0]^s[5] and setting s={fb,s[8:1]}. The FIFO always receives plain bytes.
- R7: With `cfg_crc_en`=1, the two bytes after the payload carry the CRC, high byte first. The CRC uses polynomial 0x1021, starts from 0x1D0F, processes each plain payload byte MSB first, and is sent inverted. After the second CRC byte, `crc_ok` shows whether the bytes matched. With `cfg_crc_en`=0, `crc_ok` keeps its value.
- R8: When the CRC check fails and `cfg_autoclr_en`=1, the FIFO is emptied. When it fails with `cfg_autoclr_en`=0, the payload bytes remain.
- R9: `payload_ready` is high for exactly one cycle, in the cycle after the last byte of an accepted packet is taken. That last byte is the second CRC byte, or the last payload byte when the CRC is disabled.
- R10: The FIFO holds 64 bytes. `fifo_rdata` shows the oldest byte, and `fifo_rd` pops it. Pops are ignored while a packet is being received. Payload bytes that arrive while the FIFO is full are discarded, and the packet still completes.
- R11: After reset the FIFO is empty with level 0, and `payload_ready` and `crc_ok` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse after sync detection, starts a packet |
| byte_vld | input | 1 | A received byte is present on byte_data |
| byte_data | input | 8 | Received byte from the deserializer |
| cfg_var_len | input | 1 | 1: length byte leads the payload; 0: fixed length |
| cfg_max_len | input | 7 | Fixed payload length, or limit for the length byte |
| cfg_node_addr | input | 8 | Node address for the filter |
| cfg_addr_mode | input | 2 | Address filter mode |
| cfg_white_en | input | 1 | Remove whitening |
| cfg_crc_en | input | 1 | Two CRC bytes follow the payload and are checked |
| cfg_autoclr_en | input | 1 | Flush FIFO on CRC failure |
| fifo_rd | input | 1 | Pop the oldest FIFO byte |
| fifo_rdata | output | 8 | Oldest FIFO byte |
| fifo_level | output | 7 | Number of bytes in the FIFO |
| fifo_empty | output | 1 | FIFO holds no bytes |
| fifo_full | output | 1 | FIFO holds 64 bytes |
| payload_ready | output | 1 | One-cycle pulse at the end of an accepted packet |
| crc_ok | output | 1 | Result of the last CRC check |

## Verification
Directed packets probe the edges of each function:
- a length equal to the limit against one above it, to locate the comparison;
- each filter mode against the node address, 0x00 and 0xFF, which shows that the broadcast acceptance is graded by mode;
- corrupted CRCs with and without auto-clear, which separates flushing from merely flagging;
- a 70-byte fixed packet, which shows that overflow bytes are discarded while the CRC still covers them;
- a pop issued mid-packet, which shows that draining is blocked during reception.

Seeded random packets then mix length mode, filter mode, address choice, whitening, CRC and corruption. These mixes catch errors in the whitening mask sequence and in CRC bit ordering, because either error leaves the stored bytes or `crc_ok` disagreeing with the bench's own model.

// File: rtl/pkt_rx_pkg.sv
// Shared types and bytewise helper functions for the packet receive path.
// Assumes byte-wide data and MSB-first bit order in both CRC and whitening.
package pkt_rx_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_LEN    = 3'd1,
        S_PAY    = 3'd2,
        S_CRC_HI = 3'd3,
        S_CRC_LO = 3'd4
    } rx_state_e;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'h1D0F;
    localparam logic [8:0]  PN_SEED  = 9'h1FF;

    // Fold one byte into the CRC, MSB first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[15] ^ d[i];
            r  = {r[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
        end
        return r;
    endfunction

    // Advance the PN9 register by one byte (eight steps).
    function automatic logic [8:0] pn9_adv8(input logic [8:0] s);
        logic [8:0] r;
        r = s;
        for (int i = 0; i < 8; i++) begin
            r = {r[0] ^ r[5], r[8:1]};
        end
        return r;
    endfunction

    // Address filter decision for the four filter modes.
    function automatic logic addr_pass(input logic [1:0] mode, input logic [7:0] a,
                                       input logic [7:0] node);
        logic r;
        case (mode)
            2'b00:   r = 1'b1;
            2'b01:   r = (a == node);
            2'b10:   r = (a == node) || (a == 8'h00);
            default: r = (a == node) || (a == 8'h00) || (a == 8'hFF);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/prx_dewhiten.sv
// PN9 dewhitening mask generator. Restarts at each frame start and
// advances by one byte for every byte consumed inside a frame.
// Assumes restart and advance never coincide (start pulse has no byte).
module prx_dewhiten
    import pkt_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    input  logic              enable,
    output logic [DATA_W-1:0] mask
);
    logic [8:0] pn_q;

    // Register holds the mask source for the byte now on the input.
    always_ff @(posedge clk) begin
        if (!rst_n)       pn_q <= PN_SEED;
        else if (restart) pn_q <= PN_SEED;
        else if (advance) pn_q <= pn9_adv8(pn_q);
    end

    // Mask is zero when whitening is off.
    assign mask = enable ? DATA_W'(pn_q[7:0]) : '0;

    // R6: the PN9 register never locks up in the all-zero state.
    p_lfsr_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pn_q != 9'h000);

endmodule

// File: rtl/prx_crc16.sv
// Running CRC-16 over plain payload bytes; cleared at frame start.
// Assumes clear and update never occur in the same cycle.
module prx_crc16
    import pkt_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        update,
    input  logic [7:0]  data,
    output logic [15:0] crc
);
    logic [15:0] crc_q;

    // Accumulate one byte per update, restart from the seed on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= CRC_SEED;
        else if (clear)  crc_q <= CRC_SEED;
        else if (update) crc_q <= crc16_byte(crc_q, data);
    end

    assign crc = crc_q;

    // R7: the accumulator only moves when a payload byte is folded in.
    p_crc_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !update) |=> $stable(crc_q));

endmodule

// File: rtl/prx_fifo.sv
// Receive FIFO with first-word-fall-through read, a frame-start mark,
// rollback to that mark and a full flush. Writes when full are dropped.
// Assumes no pops occur between mark and rollback (the top blocks them).
module prx_fifo #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          rd_en,
    input  logic                          mark,
    input  logic                          rollback,
    input  logic                          flush,
    output logic [DATA_W-1:0]             rd_data,
    output logic [$clog2(DEPTH+1)-1:0]    level,
    output logic                          empty,
    output logic                          full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr, mark_ptr;
    logic [CW-1:0]     count, mark_cnt;
    logic              do_wr, do_rd;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];
    assign level   = count;

    // Storage array, written only when space remains.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    // Snapshot of the write side taken at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_ptr <= '0;
            mark_cnt <= '0;
        end else if (mark) begin
            mark_ptr <= wr_ptr;
            mark_cnt <= count;
        end
    end

    // Pointer and occupancy update; flush beats rollback beats traffic.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (rollback) begin
            wr_ptr <= mark_ptr;
            count  <= mark_cnt;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_wr) - CW'(do_rd);
        end
    end

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_full_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && !flush && !rollback) |=> full);
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/pkt_rx_filter.sv
// Packet receive handler: parses the length, filters by address, removes
// whitening, checks the CRC and loads plain payload bytes into the FIFO.
// Assumes configuration is stable during a packet, frame_start never comes
// with byte_vld, and cfg_max_len >= 1 in fixed-length mode.
module pkt_rx_filter
    import pkt_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int LEN_W      = 7,
    parameter int DATA_W     = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            frame_start,
    input  logic                            byte_vld,
    input  logic [DATA_W-1:0]               byte_data,
    input  logic                            cfg_var_len,
    input  logic [LEN_W-1:0]                cfg_max_len,
    input  logic [DATA_W-1:0]               cfg_node_addr,
    input  logic [1:0]                      cfg_addr_mode,
    input  logic                            cfg_white_en,
    input  logic                            cfg_crc_en,
    input  logic                            cfg_autoclr_en,
    input  logic                            fifo_rd,
    output logic [DATA_W-1:0]               fifo_rdata,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
    output logic                            fifo_empty,
    output logic                            fifo_full,
    output logic                            payload_ready,
    output logic                            crc_ok
);
    localparam int RW = (LEN_W > DATA_W) ? LEN_W : DATA_W;

    rx_state_e         state, st_n;
    logic [RW-1:0]     remain, remain_n, len_ext, limit_ext;
    logic              addr_due, addr_due_n;
    logic [7:0]        crc_hi, crc_hi_n;
    logic              crc_ok_q, crc_ok_n, ready_q;
    logic [DATA_W-1:0] mask, plain;
    logic [15:0]       crc_val;
    logic              in_frame, take, len_over, addr_hit;
    logic              wr_en, crc_upd, rollback, flush, done, pay_end;

    assign in_frame  = (state != S_IDLE);
    assign take      = byte_vld && in_frame && !frame_start;
    assign plain     = byte_data ^ mask;
    assign len_ext   = RW'(plain);
    assign limit_ext = RW'(cfg_max_len);
    assign len_over  = (len_ext > limit_ext);
    assign addr_hit  = addr_pass(cfg_addr_mode, 8'(plain), 8'(cfg_node_addr));

    prx_dewhiten #(.DATA_W(DATA_W)) u_dewhiten (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (frame_start),
        .advance (take),
        .enable  (cfg_white_en),
        .mask    (mask)
    );

    prx_crc16 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (frame_start),
        .update (crc_upd),
        .data   (8'(plain)),
        .crc    (crc_val)
    );

    prx_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (plain),
        .rd_en    (fifo_rd && !in_frame),
        .mark     (frame_start),
        .rollback (rollback),
        .flush    (flush),
        .rd_data  (fifo_rdata),
        .level    (fifo_level),
        .empty    (fifo_empty),
        .full     (fifo_full)
    );

    // Frame parser: decides per byte whether to store, drop or finish.
    always_comb begin
        st_n       = state;
        remain_n   = remain;
        addr_due_n = addr_due;
        crc_hi_n   = crc_hi;
        crc_ok_n   = crc_ok_q;
        wr_en      = 1'b0;
        crc_upd    = 1'b0;
        rollback   = 1'b0;
        flush      = 1'b0;
        done       = 1'b0;
        pay_end    = 1'b0;
        if (frame_start) begin
            st_n       = cfg_var_len ? S_LEN : S_PAY;
            remain_n   = limit_ext;
            addr_due_n = (cfg_addr_mode != 2'b00);
        end else if (take) begin
            case (state)
                S_LEN: begin
                    if (len_over) begin
                        st_n = S_IDLE;
                    end else begin
                        wr_en      = 1'b1;
                        crc_upd    = 1'b1;
                        remain_n   = len_ext;
                        addr_due_n = (cfg_addr_mode != 2'b00) && (len_ext != '0);
                        if (len_ext == '0) pay_end = 1'b1;
                        else               st_n    = S_PAY;
                    end
                end
                S_PAY: begin
                    if (addr_due && !addr_hit) begin
                        rollback = 1'b1;
                        st_n     = S_IDLE;
                    end else begin
                        wr_en      = 1'b1;
                        crc_upd    = 1'b1;
                        addr_due_n = 1'b0;
                        remain_n   = remain - 1'b1;
                        if (remain == RW'(1)) pay_end = 1'b1;
                    end
                end
                S_CRC_HI: begin
                    crc_hi_n = 8'(plain);
                    st_n     = S_CRC_LO;
                end
                S_CRC_LO: begin
                    crc_ok_n = ({crc_hi, 8'(plain)} == ~crc_val);
                    flush    = !crc_ok_n && cfg_autoclr_en;
                    done     = 1'b1;
                    st_n     = S_IDLE;
                end
                default: st_n = S_IDLE;
            endcase
            if (pay_end) begin
                if (cfg_crc_en) begin
                    st_n = S_CRC_HI;
                end else begin
                    done = 1'b1;
                    st_n = S_IDLE;
                end
            end
        end
    end

    // Parser state and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            remain   <= '0;
            addr_due <= 1'b0;
            crc_hi   <= '0;
            crc_ok_q <= 1'b0;
            ready_q  <= 1'b0;
        end else begin
            state    <= st_n;
            remain   <= remain_n;
            addr_due <= addr_due_n;
            crc_hi   <= crc_hi_n;
            crc_ok_q <= crc_ok_n;
            ready_q  <= done;
        end
    end

    assign payload_ready = ready_q;
    assign crc_ok        = crc_ok_q;

    p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        payload_ready |=> !payload_ready);
    p_ready_at_rest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        payload_ready |-> (state == S_IDLE));
    p_oversize_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && state == S_LEN && len_over) |=>
            (!payload_ready && fifo_level == $past(fifo_level)));
    p_reject_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && state == S_PAY && addr_due && !addr_hit) |=>
            (!payload_ready && state == S_IDLE));
    p_no_drain_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && fifo_rd && !flush && !rollback) |=>
            (fifo_level >= $past(fifo_level)));
    p_crc_end_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && state == S_CRC_LO) |=> payload_ready);

endmodule

// File: tb/pkt_rx_filter_bench.sv
`timescale 1ns/1ps
// Bench for pkt_rx_filter: directed corner packets plus seeded random ones,
// each checked against a model built from the requirements.
module pkt_rx_filter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       cfg_var_len = 1'b0;
    logic [6:0] cfg_max_len = 7'd1;
    logic [7:0] cfg_node_addr = 8'h00;
    logic [1:0] cfg_addr_mode = 2'b00;
    logic       cfg_white_en = 1'b0;
    logic       cfg_crc_en = 1'b0;
    logic       cfg_autoclr_en = 1'b0;
    logic       fifo_rd = 1'b0;
    logic [7:0] fifo_rdata;
    logic [6:0] fifo_level;
    logic       fifo_empty, fifo_full, payload_ready, crc_ok;

    int checks = 0;
    int fails = 0;
    int ready_seen = 0;
    bit finished = 1'b0;
    bit exp_crc_ok = 1'b0;
    logic [7:0] pl [0:79];
    logic [7:0] tx [0:81];

    always #2 clk = ~clk;

    pkt_rx_filter u_pkt_rx_filter (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_vld(byte_vld),
        .byte_data(byte_data), .cfg_var_len(cfg_var_len), .cfg_max_len(cfg_max_len),
        .cfg_node_addr(cfg_node_addr), .cfg_addr_mode(cfg_addr_mode),
        .cfg_white_en(cfg_white_en), .cfg_crc_en(cfg_crc_en),
        .cfg_autoclr_en(cfg_autoclr_en), .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata),
        .fifo_level(fifo_level), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .payload_ready(payload_ready), .crc_ok(crc_ok)
    );

    always @(negedge clk) if (payload_ready) ready_seen++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] model_crc(input int n);
        logic [15:0] c = 16'h1D0F;
        for (int k = 0; k < n; k++) begin
            for (int b = 7; b >= 0; b--) begin
                if (c[15] ^ pl[k][b]) c = (c << 1) ^ 16'h1021;
                else                  c = c << 1;
            end
        end
        return c;
    endfunction

    function automatic bit model_pass(input logic [1:0] m, input logic [7:0] a,
                                      input logic [7:0] node);
        if (m == 2'd0) return 1'b1;
        if (a == node) return 1'b1;
        if (m >= 2'd2 && a == 8'h00) return 1'b1;
        if (m == 2'd3 && a == 8'hFF) return 1'b1;
        return 1'b0;
    endfunction

    task automatic send_byte(input logic [7:0] d);
        @(negedge clk); byte_vld = 1'b1; byte_data = d;
        @(negedge clk); byte_vld = 1'b0;
    endtask

    task automatic run_pkt(input string tag, input bit var_m, input int lim, input int vlen,
                           input logic [7:0] node, input logic [1:0] mode,
                           input logic [7:0] addr_v, input bit white, input bit crc,
                           input bit aclr, input bit bad_crc, input bit poke_rd);
        int n, total, apos, exp_lvl;
        bit has_addr, drop, rej, acc;
        logic [15:0] c;
        logic [8:0] s;
        n = var_m ? vlen + 1 : lim;
        for (int k = 0; k < n; k++) pl[k] = 8'($urandom);
        if (var_m) pl[0] = 8'(vlen);
        apos = var_m ? 1 : 0;
        has_addr = (n > apos) && (mode != 2'd0);
        if (n > apos) pl[apos] = addr_v;
        for (int k = 0; k < n; k++) tx[k] = pl[k];
        c = ~model_crc(n);
        tx[n] = c[15:8];
        tx[n+1] = c[7:0];
        total = n + (crc ? 2 : 0);
        s = 9'h1FF;
        if (white) begin
            for (int k = 0; k < total; k++) begin
                tx[k] = tx[k] ^ s[7:0];
                for (int j = 0; j < 8; j++) s = {s[0] ^ s[5], s[8:1]};
            end
        end
        if (bad_crc && crc) tx[n+1] = tx[n+1] ^ 8'h01;
        cfg_var_len = var_m; cfg_max_len = 7'(lim); cfg_node_addr = node;
        cfg_addr_mode = mode; cfg_white_en = white; cfg_crc_en = crc;
        cfg_autoclr_en = aclr;
        ready_seen = 0;
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        for (int k = 0; k < total; k++) begin
            send_byte(tx[k]);
            if (poke_rd && k == 0) begin
                fifo_rd = 1'b1; @(negedge clk); fifo_rd = 1'b0;
            end
        end
        repeat (3) @(negedge clk);
        drop = var_m && (vlen > lim);
        rej = !drop && has_addr && !model_pass(mode, addr_v, node);
        acc = !drop && !rej;
        if (acc && crc) exp_crc_ok = !bad_crc;
        exp_lvl = acc ? ((crc && bad_crc && aclr) ? 0 : (n > 64 ? 64 : n)) : 0;
        // R3 R5 R9: one pulse only for accepted packets
        chk(ready_seen == (acc ? 1 : 0), drop ? "R3" : (rej ? "R5" : "R9"),
            {tag, " ready pulses"}, ready_seen, acc ? 1 : 0);
        // R1 R2 R8 R10: stored byte count
        chk(int'(fifo_level) == exp_lvl, (crc && bad_crc) ? "R8" : (var_m ? "R2" : "R1"),
            {tag, " level"}, int'(fifo_level), exp_lvl);
        // R7: CRC status
        chk(crc_ok == exp_crc_ok, "R7", {tag, " crc_ok"}, int'(crc_ok), int'(exp_crc_ok));
        // R6: plain contents in order
        for (int k = 0; k < exp_lvl; k++) begin
            if (fifo_rdata !== pl[k]) begin
                chk(1'b0, "R6", {tag, " byte"}, int'(fifo_rdata), int'(pl[k]));
                break;
            end
            fifo_rd = 1'b1; @(negedge clk); fifo_rd = 1'b0;
        end
        while (!fifo_empty) begin
            fifo_rd = 1'b1; @(negedge clk); fifo_rd = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int mode_i, sel, vl, lm;
        logic [7:0] nd, av;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(fifo_empty && fifo_level == 7'd0 && !payload_ready && !crc_ok, "R11",
            "reset state", int'(fifo_level), 0);
        // R1: fixed, plain
        run_pkt("fixed5", 1'b0, 5, 0, 8'h3C, 2'd0, 8'h00, 0, 0, 0, 0, 0);
        // R2 R10: variable, read ignored mid-frame
        run_pkt("var_poke", 1'b1, 40, 12, 8'h3C, 2'd0, 8'h00, 1, 1, 0, 0, 1);
        // R3: boundary equal and above
        run_pkt("len_eq", 1'b1, 20, 20, 8'h3C, 2'd0, 8'h00, 1, 1, 0, 0, 0);
        run_pkt("len_over", 1'b1, 20, 21, 8'h3C, 2'd0, 8'h00, 1, 1, 0, 0, 0);
        // R4 R5: filter modes
        run_pkt("m1_zero", 1'b1, 30, 8, 8'h5A, 2'd1, 8'h00, 0, 1, 0, 0, 0);
        run_pkt("m1_node", 1'b1, 30, 8, 8'h5A, 2'd1, 8'h5A, 0, 1, 0, 0, 0);
        run_pkt("m2_zero", 1'b0, 9, 0, 8'h5A, 2'd2, 8'h00, 1, 0, 0, 0, 0);
        run_pkt("m2_ff", 1'b0, 9, 0, 8'h5A, 2'd2, 8'hFF, 1, 0, 0, 0, 0);
        run_pkt("m3_ff", 1'b1, 30, 6, 8'h5A, 2'd3, 8'hFF, 1, 1, 0, 0, 0);
        run_pkt("m3_other", 1'b1, 30, 6, 8'h5A, 2'd3, 8'h11, 1, 1, 0, 0, 0);
        run_pkt("len0_filt", 1'b1, 30, 0, 8'h5A, 2'd1, 8'h00, 1, 1, 0, 0, 0);
        // R7 R8: CRC failure with and without auto-clear
        run_pkt("crc_bad_keep", 1'b1, 40, 10, 8'h5A, 2'd0, 8'h00, 1, 1, 0, 1, 0);
        run_pkt("crc_bad_clr", 1'b1, 40, 10, 8'h5A, 2'd0, 8'h00, 1, 1, 1, 1, 0);
        run_pkt("crc_good_clr", 1'b0, 16, 0, 8'h5A, 2'd0, 8'h00, 0, 1, 1, 0, 0);
        // R10: overflow beyond 64 bytes
        run_pkt("overflow", 1'b0, 70, 0, 8'h5A, 2'd0, 8'h00, 1, 1, 0, 0, 0);
        for (int it = 0; it < 40; it++) begin
            mode_i = int'($urandom_range(3, 0));
            nd = 8'($urandom_range(254, 1));
            sel = int'($urandom_range(3, 0));
            av = (sel == 0) ? nd : (sel == 1) ? 8'h00 : (sel == 2) ? 8'hFF : 8'($urandom);
            vl = int'($urandom_range(40, 0));
            lm = ($urandom_range(3, 0) == 0 && vl > 0) ? vl - 1 : vl + int'($urandom_range(19, 0));
            if ($urandom_range(1, 0) == 1)
                run_pkt("rand_var", 1'b1, lm, vl, nd, 2'(mode_i), av, 1'($urandom),
                        1'($urandom), 1'($urandom), 1'($urandom), 0);
            else
                run_pkt("rand_fix", 1'b0, vl + 1, 0, nd, 2'(mode_i), av, 1'($urandom),
                        1'($urandom), 1'($urandom), 1'($urandom), 0);
        end
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule